// File: doc/BRIEF.md
# Parameter-Set DMA Transfer Engine

This block moves data for a single DMA channel. A host first writes one or more six-word parameter sets into a 2 KB parameter memory. Each set holds an options word, a source address, a destination address, an element count paired with a frame count, an element reload value and a link pointer. A `start` pulse loads the set at parameter byte address 0. From then on, every synchronisation event on `sync_evt` moves either one element or one whole frame, depending on the frame-sync option. Each element is one read from the source and one write to the destination over a valid/ready memory master.

After each element, the source and destination addresses are stepped on their own: each is held, incremented or decremented by the element size in bytes. A block is made of (frame count + 1) frames. The first frame holds the element count number of elements, and every later frame holds the reload value. When the block ends, the engine either goes idle or fetches the set named by its link pointer and carries on. If the options ask for it, it also pulses `done` with a 4-bit completion code.

Memory handshake: a request (`mem_valid` with address, direction, size and write data) stays unchanged until a cycle in which `mem_ready` is high. The transfer takes place at that clock edge. For a read, `mem_rdata` must be valid in that same cycle. The memory applies back-pressure simply by holding `mem_ready` low.

Top module: `psdma_engine`

Set layout (word offsets within a set): 0 options, 1 source, 2 destination, 3 element count [15:0] and frame count [31:16], 4 reload [15:0] and link byte address [31:16], 5 unused. Options bits: [1:0] size (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), [3:2] source mode and [5:4] destination mode (0 hold, 1 increment, 2 decrement, 3 hold), [6] frame-sync, [7] link, [8] completion enable, [12:9] completion code.

## Requirements
- R1: While reset is asserted, `mem_valid` and `done` are 0.
- R2: With options bit 6 = 0, each sync event moves exactly one element. The move is a read (`mem_write` = 0) of the source address followed by a write (`mem_write` = 1) of the destination address.
- R3: After each element, source and destination addresses follow their own modes (bits [3:2] and [5:4]: 0 hold, 1 add, 2 subtract). The step is 1, 2 or 4 bytes, according to the element size.
- R4: `mem_size` carries the element size (0, 1 or 2; option value 3 is sent as 2). Write data is the read data with the bits above the element width cleared.
- R5: A block moves the element count (word 3 [15:0]) elements in its first frame. It then moves the reload value (word 4 [15:0]) elements in each of the frame count (word 3 [31:16]) further frames.
- R6: With options bit 6 = 1, one sync event moves every element of the current frame back to back.
- R7: Sync events that arrive while a frame is still being moved are counted. Each is later serviced as a separate frame.
- R8: With link bit 7 = 0, the engine goes idle at block end. Sync events received after that cause no memory traffic.
- R9: With link bit 7 = 1, at block end the engine loads the set at parameter byte address word 4 [31:16] and continues with it.
- R10: At block end, `done` pulses for one cycle with `done_code` = options [12:9] if bit 8 = 1. Otherwise `done` stays 0.
- R11: While `mem_valid` = 1 and `mem_ready` = 0, the request address, direction and write data stay unchanged.
- R12: A parameter word written through `pr_we`/`pr_addr`/`pr_wdata` reads back combinationally on `pr_rdata` at the same word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the set at parameter address 0 and arm the channel (used only when idle) |
| sync_evt | input | 1 | Synchronisation event, one per cycle high |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | DW | Write data, low-aligned |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | DW | Read data, valid with `mem_ready` on a read |
| pr_we | input | 1 | Parameter memory write enable |
| pr_addr | input | PAW | Parameter memory word address |
| pr_wdata | input | 32 | Parameter memory write data |
| pr_rdata | output | 32 | Parameter memory read data |
| done | output | 1 | Block-complete pulse |
| done_code | output | 4 | Completion code of the last finished block |

## Verification
A wrong counter or state shows up at the memory port as soon as the next element moves. A corrupted address or step mode gives the wrong `mem_addr` on the next request. A wrong element or frame count gives an extra or missing transfer, or a `done` pulse out of place, at the first frame boundary. A lost or duplicated pending sync shows up as a frame count that does not match the number of events, within one frame time. The reference model predicts every memory handshake and every cycle of `done`, so each of these faults is seen within a few cycles of its first effect.

// File: rtl/psdma_pkg.sv
package psdma_pkg;
  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2,
    AM_RSV  = 2'd3
  } amode_t;

  typedef struct packed {
    logic [3:0] code;
    logic       cmp_en;
    logic       link_en;
    logic       fsync;
    amode_t     dmode;
    amode_t     smode;
    logic [1:0] esize;
  } opt_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_WAIT, S_RD, S_WR
  } state_t;

  localparam int SET_WORDS  = 6;
  localparam int LOAD_WORDS = 5;
  localparam int OPT_BITS   = 13;
  localparam int CNT_W      = 16;
endpackage

// File: rtl/psdma_pram.sv
module psdma_pram #(
  parameter int WORDS = 512,
  parameter int PAW   = 9
) (
  input  logic           clk,
  input  logic           we,
  input  logic [PAW-1:0] waddr,
  input  logic [31:0]    wdata,
  input  logic [PAW-1:0] ra_host,
  output logic [31:0]    rd_host,
  input  logic [PAW-1:0] ra_eng,
  output logic [31:0]    rd_eng
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_host = mem[ra_host];
  assign rd_eng  = mem[ra_eng];
endmodule

// File: rtl/psdma_addr_step.sv
module psdma_addr_step
  import psdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  amode_t        mode,
  input  logic [1:0]    esize,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  always_comb begin
    step = (esize == 2'd3) ? AW'(4) : (AW'(1) << esize);
    unique case (mode)
      AM_INC:  nxt = cur + step;
      AM_DEC:  nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/psdma_sync_pend.sv
module psdma_sync_pend #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic take,
  output logic nz
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else begin
      unique case ({inc, take})
        2'b10:   if (cnt != '1) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign nz = (cnt != '0);
endmodule

// File: rtl/psdma_engine.sv
module psdma_engine
  import psdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PRAM_BYTES = 2048,
  parameter int PEND_W     = 4,
  localparam int PR_WORDS  = PRAM_BYTES / 4,
  localparam int PAW       = $clog2(PR_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           sync_evt,
  output logic           mem_valid,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           pr_we,
  input  logic [PAW-1:0] pr_addr,
  input  logic [31:0]    pr_wdata,
  output logic [31:0]    pr_rdata,
  output logic           done,
  output logic [3:0]     done_code
);
  state_t           st;
  logic [2:0]       ld_idx;
  logic [PAW-1:0]   ld_base;
  opt_t             opt;
  logic [AW-1:0]    cur_addr [2];
  logic [AW-1:0]    nxt_addr [2];
  logic [CNT_W-1:0] ecnt, fcnt, erld, lnk;
  logic [DW-1:0]    hold, lane_mask;
  logic             done_q;
  logic [3:0]       code_q;
  logic [31:0]      eng_rdata;
  logic             pend_nz, last_elem, last_blk, wr_fire, stop_now;
  logic [1:0]       eff_size;

  psdma_pram #(.WORDS(PR_WORDS), .PAW(PAW)) u_pram (
    .clk(clk), .we(pr_we), .waddr(pr_addr), .wdata(pr_wdata),
    .ra_host(pr_addr), .rd_host(pr_rdata),
    .ra_eng(ld_base + PAW'(ld_idx)), .rd_eng(eng_rdata)
  );

  // index 0 steps the source, index 1 the destination
  for (genvar g = 0; g < 2; g++) begin : g_step
    psdma_addr_step #(.AW(AW)) u_step (
      .cur(cur_addr[g]),
      .mode(g == 0 ? opt.smode : opt.dmode),
      .esize(opt.esize),
      .nxt(nxt_addr[g])
    );
  end

  assign wr_fire   = (st == S_WR) && mem_ready;
  assign last_elem = (ecnt <= CNT_W'(1));
  assign last_blk  = last_elem && (fcnt == '0);
  assign stop_now  = wr_fire && last_blk && !opt.link_en;

  psdma_sync_pend #(.PW(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(stop_now),
    .inc(sync_evt && (st != S_IDLE)),
    .take((st == S_WAIT) && pend_nz),
    .nz(pend_nz)
  );

  assign eff_size = (opt.esize == 2'd3) ? 2'd2 : opt.esize;

  always_comb begin
    unique case (eff_size)
      2'd0:    lane_mask = DW'(8'hFF);
      2'd1:    lane_mask = DW'(16'hFFFF);
      default: lane_mask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ld_idx   <= '0;
      ld_base  <= '0;
      opt      <= '0;
      cur_addr <= '{default: '0};
      ecnt     <= '0;
      fcnt     <= '0;
      erld     <= '0;
      lnk      <= '0;
      hold     <= '0;
      done_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          ld_base <= '0;
          ld_idx  <= '0;
          st      <= S_LOAD;
        end
        S_LOAD: begin
          unique case (ld_idx)
            3'd0: opt <= opt_t'(eng_rdata[OPT_BITS-1:0]);
            3'd1: cur_addr[0] <= eng_rdata[AW-1:0];
            3'd2: cur_addr[1] <= eng_rdata[AW-1:0];
            3'd3: begin
              ecnt <= eng_rdata[15:0];
              fcnt <= eng_rdata[31:16];
            end
            default: begin
              erld <= eng_rdata[15:0];
              lnk  <= eng_rdata[31:16];
            end
          endcase
          ld_idx <= ld_idx + 3'd1;
          if (ld_idx == 3'(LOAD_WORDS - 1)) st <= S_WAIT;
        end
        S_WAIT: if (pend_nz) st <= S_RD;
        S_RD: if (mem_ready) begin
          hold <= mem_rdata & lane_mask;
          st   <= S_WR;
        end
        S_WR: if (mem_ready) begin
          cur_addr <= nxt_addr;
          if (last_elem) begin
            ecnt <= erld;
            if (fcnt == '0) begin
              done_q <= opt.cmp_en;
              code_q <= opt.code;
              if (opt.link_en) begin
                ld_base <= lnk[PAW+1:2];
                ld_idx  <= '0;
                st      <= S_LOAD;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              fcnt <= fcnt - 1'b1;
              st   <= S_WAIT;
            end
          end else begin
            ecnt <= ecnt - 1'b1;
            st   <= opt.fsync ? S_RD : S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_valid = (st == S_RD) || (st == S_WR);
  assign mem_write = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? cur_addr[1] : cur_addr[0];
  assign mem_size  = eff_size;
  assign mem_wdata = hold;
  assign done      = done_q;
  assign done_code = code_q;
endmodule

// File: rtl/psdma_checks.sv
module psdma_checks #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          done
);
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                               && $stable(mem_write) && $stable(mem_wdata));

  a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_size != 2'd3);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid && mem_ready && mem_write));

  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && !$past(mem_valid && mem_write)
      |-> $past(mem_valid && mem_ready && !mem_write));

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !mem_valid && !done);
endmodule

bind psdma_engine psdma_checks #(.AW(AW), .DW(DW)) u_checks (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .done(done)
);

// File: tb/tb_psdma_engine.sv
module tb_psdma_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PAW = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sync_evt = 1'b0;
  logic mem_ready = 1'b0, pr_we = 1'b0;
  logic [PAW-1:0] pr_addr = '0;
  logic [31:0] pr_wdata = '0, pr_rdata;
  logic mem_valid, mem_write, done;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [3:0] done_code;

  always #4 clk = ~clk;

  psdma_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_evt(sync_evt),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .pr_we(pr_we), .pr_addr(pr_addr),
    .pr_wdata(pr_wdata), .pr_rdata(pr_rdata), .done(done), .done_code(done_code)
  );

  function automatic logic [31:0] memfun(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h1234_5678;
  endfunction
  assign mem_rdata = memfun(mem_addr);

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    bit          fin;
    bit          den;
    logic [3:0]  code;
  } xact_t;

  xact_t expq[$];
  logic [31:0] shadow [512];
  int total = 0, bad = 0, n_wr = 0, n_done = 0, cyc = 0;
  bit throttle = 1'b0, exp_done = 1'b0, prev_stall = 1'b0, prev_we = 1'b0;
  logic [3:0] exp_code = '0;
  logic [31:0] prev_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: per-clock comparison of handshakes and done
  always @(negedge clk) begin
    xact_t x;
    cyc++;
    if (rst_n) begin
      check(done === exp_done && (!exp_done || done_code === exp_code), "R10",
            "done/code", {27'd0, done, done_code}, {27'd0, exp_done, exp_code});
      if (done) n_done++;
      exp_done = 1'b0;
      if (prev_stall)
        check(mem_valid === 1'b1 && mem_addr === prev_addr && mem_write === prev_we,
              "R11", "request changed under stall", mem_addr, prev_addr);
      mem_ready = throttle ? (cyc % 3 != 0) : 1'b1;
      prev_stall = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_we = mem_write;
      if (mem_valid && mem_ready) begin
        if (mem_write) n_wr++;
        if (expq.size() == 0) begin
          check(1'b0, "R8", "unexpected transfer", mem_addr, 32'd0);
        end else begin
          x = expq.pop_front();
          check(mem_write === x.we, "R2", "direction", {31'd0, mem_write}, {31'd0, x.we});
          check(mem_addr === x.addr, "R3", "address", mem_addr, x.addr);
          check(mem_size === x.size, "R4", "size", {30'd0, mem_size}, {30'd0, x.size});
          if (x.we) check(mem_wdata === x.data, "R4", "write data", mem_wdata, x.data);
          if (x.fin && x.den) begin
            exp_done = 1'b1;
            exp_code = x.code;
          end
        end
      end
    end
  end

  function automatic logic [31:0] stepf(input logic [31:0] a, input logic [1:0] m,
                                        input int st);
    if (m == 2'd1) return a + st;
    if (m == 2'd2) return a - st;
    return a;
  endfunction

  task automatic model_chain(input int base0);
    int base, sz, stp, n;
    logic [31:0] o, src, dst, mask;
    logic [15:0] e, f, r, lk;
    xact_t x;
    base = base0;
    for (int s = 0; s < 8; s++) begin
      o = shadow[base]; src = shadow[base+1]; dst = shadow[base+2];
      e = shadow[base+3][15:0]; f = shadow[base+3][31:16];
      r = shadow[base+4][15:0]; lk = shadow[base+4][31:16];
      sz = (o[1:0] == 2'd3) ? 2 : int'(o[1:0]);
      stp = 1 << sz;
      mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      for (int fr = 0; fr <= int'(f); fr++) begin
        n = (fr == 0) ? int'(e) : int'(r);
        for (int k = 0; k < n; k++) begin
          x.we = 1'b0; x.addr = src; x.data = '0; x.size = 2'(sz);
          x.fin = 1'b0; x.den = 1'b0; x.code = '0;
          expq.push_back(x);
          x.we = 1'b1; x.addr = dst; x.data = memfun(src) & mask;
          x.fin = (fr == int'(f)) && (k == n - 1); x.den = o[8]; x.code = o[12:9];
          expq.push_back(x);
          src = stepf(src, o[3:2], stp);
          dst = stepf(dst, o[5:4], stp);
        end
      end
      if (!o[7]) break;
      base = int'(lk[10:2]);
    end
  endtask

  task automatic pram_write(input int w, input logic [31:0] d);
    @(negedge clk);
    pr_we = 1'b1; pr_addr = PAW'(w); pr_wdata = d;
    @(negedge clk);
    pr_we = 1'b0;
    shadow[w] = d;
  endtask

  function automatic logic [31:0] mkopt(input int sz, input int sm, input int dm,
      input bit fs, input bit lk, input bit ce, input int code);
    return {19'd0, 4'(code), ce, lk, fs, 2'(dm), 2'(sm), 2'(sz)};
  endfunction

  task automatic write_set(input int base, input logic [31:0] o, input logic [31:0] s,
      input logic [31:0] d, input int e, input int f, input int r, input int lk);
    pram_write(base, o);
    pram_write(base + 1, s);
    pram_write(base + 2, d);
    pram_write(base + 3, {16'(f), 16'(e)});
    pram_write(base + 4, {16'(lk), 16'(r)});
    pram_write(base + 5, 32'd0);
  endtask

  task automatic pulse(ref logic sig, input int len);
    @(negedge clk); sig = 1'b1;
    repeat (len) @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, d0;
    wait_cyc(3);
    check(mem_valid === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          {30'd0, mem_valid, done}, 32'd0);
    rst_n = 1'b1;

    // R12 host port
    pram_write(40, 32'hCAFE_0123);
    pram_write(41, 32'h0BAD_F00D);
    @(negedge clk); pr_addr = 9'd40; #1;
    check(pr_rdata === 32'hCAFE_0123, "R12", "readback 40", pr_rdata, 32'hCAFE_0123);
    @(negedge clk); pr_addr = 9'd41; #1;
    check(pr_rdata === 32'h0BAD_F00D, "R12", "readback 41", pr_rdata, 32'h0BAD_F00D);

    // element mode, 32-bit, inc/inc, 2 frames of 3, completion code 5
    write_set(0, mkopt(2, 1, 1, 0, 0, 1, 5), 32'h1000, 32'h2000, 3, 1, 3, 0);
    model_chain(0);
    d0 = n_done;
    pulse(start, 1);
    wait_cyc(10);
    for (int i = 0; i < 6; i++) begin
      b = n_wr;
      pulse(sync_evt, 1);
      wait_cyc(12);
      check(n_wr == b + 1, "R2", "one element per event", n_wr, b + 1);
    end
    check(expq.size() == 0, "R5", "block element total", expq.size(), 0);
    check(n_done == d0 + 1, "R10", "done count", n_done, d0 + 1);
    b = n_wr;
    pulse(sync_evt, 1);
    pulse(sync_evt, 1);
    wait_cyc(15);
    check(n_wr == b && mem_valid === 1'b0, "R8", "idle after stop", n_wr, b);

    // frame-sync, 16-bit, src decrement, dst hold, frames 4/2/2, no completion
    throttle = 1'b1;
    write_set(0, mkopt(1, 2, 0, 1, 0, 0, 7), 32'h3010, 32'h4000, 4, 2, 2, 0);
    model_chain(0);
    d0 = n_done;
    pulse(start, 1);
    wait_cyc(10);
    b = n_wr;
    pulse(sync_evt, 1);
    wait_cyc(30);
    check(n_wr == b + 4, "R6", "whole frame per event", n_wr, b + 4);
    b = n_wr;
    pulse(sync_evt, 2);
    wait_cyc(40);
    check(n_wr == b + 4, "R7", "two queued frames", n_wr, b + 4);
    check(expq.size() == 0, "R5", "reload frames", expq.size(), 0);
    check(n_done == d0, "R10", "no done when disabled", n_done, d0);

    // link: 8-bit set links to 32-bit set at byte 0x60
    throttle = 1'b0;
    write_set(0, mkopt(0, 0, 1, 0, 1, 1, 3), 32'h5003, 32'h6000, 2, 0, 2, 16'h0060);
    write_set(24, mkopt(2, 2, 1, 0, 0, 1, 9), 32'h7008, 32'h8000, 1, 1, 1, 0);
    model_chain(0);
    d0 = n_done;
    pulse(start, 1);
    wait_cyc(10);
    b = n_wr;
    for (int i = 0; i < 4; i++) begin
      pulse(sync_evt, 1);
      wait_cyc(14);
    end
    check(n_wr == b + 4, "R9", "linked set moved", n_wr, b + 4);
    check(expq.size() == 0, "R9", "chain fully served", expq.size(), 0);
    check(n_done == d0 + 2, "R10", "done per block", n_done, d0 + 2);
    check(mem_valid === 1'b0, "R8", "idle after chain", {31'd0, mem_valid}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule